// File: doc/BRIEF.md
# Cost-Weighted Time-to-Live Replacement Engine

This block keeps the replacement state for one set of a write-back, write-allocate last-level cache that sits in front of a memory whose writes cost far more than its reads. Every way carries a credit, its time to live, held as unsigned fixed point; a count of how many times the line has been written since it was filled; a valid bit; and a recency rank. A line that would be expensive to write back gets a larger credit, so it lives longer than a cheap clean line with the same recency.

The cache controller pulses an access strobe with a hit flag, the hit way and a read/write flag. On a hit the engine updates that way's credit and recency. On a miss it picks a victim: an empty way first if one exists; otherwise it drains every credit by the smallest credit in the set and takes the least recently used way among those left at zero. One cycle later it reports the victim way and whether that way holds modified data, so the controller knows to issue a write-back. It then loads the new line's credit. The incremental write costs come from a small table on an input port, indexed by write count.

Top module: `ttl_victim_sel`

## Requirements
- R1: After reset all ways are empty and `vic_vld` is 0; the first misses fill the ways in rising index order and report each victim as clean.
- R2: `vic_vld` is 1 in exactly the cycle after a miss strobe and 0 after a hit strobe or no strobe; `vic_way` and `vic_dirty` are meaningful only while it is 1.
- R3: While any way is empty, a miss fills the lowest-numbered empty way and leaves every other credit unchanged.
- R4: When all ways are valid, a miss subtracts the smallest credit from every way's credit. The victim is the way with the oldest recency among the ways whose credit is then zero.
- R5: A read miss loads the filled way's credit with one unit (1 << FRAC) and a write count of 0. A write miss loads c1 plus one unit and a write count of 1.
- R6: A write hit to a line already written i times sets its credit to the larger of (credit + c(i+1)) and (c1 + one unit), then adds one to its write count. The count saturates at NCOST-1, so every later write uses the last table entry.
- R7: A read hit to a line with write count 0 sets its credit to one unit; a read hit to a line with a nonzero write count leaves its credit unchanged.
- R8: Every hit and every fill makes the touched way the most recent. Ways that were more recent than it age by one step.
- R9: `vic_dirty` is 1 when the victim way is valid and has a nonzero write count.
- R10: Credit arithmetic saturates at the all-ones value of CREDIT_W bits and never wraps.
- R11: Table entry i sits at bits `cost_tbl[i*COST_W +: COST_W]` and holds c(i+1) in credit units. The entries must not increase with i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe, one cycle per access |
| acc_hit | input | 1 | Access hit in this set |
| acc_way | input | $clog2(WAYS) | Way that hit; ignored on a miss |
| acc_wr | input | 1 | 1 for a write access, 0 for a read |
| cost_tbl | input | NCOST*COST_W | Incremental write-cost table, entry 0 in the low bits |
| vic_vld | output | 1 | Victim report valid, one cycle after a miss |
| vic_way | output | $clog2(WAYS) | Way chosen for the fill |
| vic_dirty | output | 1 | Victim holds modified data and needs a write-back |

## Verification
The assertions take for granted that a hit strobe names a way that is already valid. They also assume the cost table does not increase with its index and stays constant while accesses are in flight. The credit and write-count properties compare the touched way against its value one cycle earlier, so they rely on the table not moving between those cycles. The stimulus raises hits only on ways that an earlier miss has filled. It ties the table to a fixed descending set of values and drives a single strobe per access, with an idle cycle between accesses.

// File: rtl/ttl_victim_sel.sv
module ttl_victim_sel #(
  parameter int WAYS     = 16,
  parameter int CREDIT_W = 12,
  parameter int FRAC     = 2,
  parameter int NCOST    = 4,
  parameter int COST_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_vld,
  input  logic                      acc_hit,
  input  logic [$clog2(WAYS)-1:0]   acc_way,
  input  logic                      acc_wr,
  input  logic [NCOST*COST_W-1:0]   cost_tbl,
  output logic                      vic_vld,
  output logic [$clog2(WAYS)-1:0]   vic_way,
  output logic                      vic_dirty
);

  localparam int IW = $clog2(WAYS);
  localparam int DW = $clog2(NCOST);
  localparam logic [CREDIT_W-1:0] ONE_C = CREDIT_W'(1) << FRAC;
  localparam logic [CREDIT_W-1:0] CMAX  = '1;
  localparam logic [DW-1:0]       DMAX  = DW'(NCOST - 1);

  logic [CREDIT_W-1:0] cr_q [WAYS];
  logic [CREDIT_W-1:0] cr_d [WAYS];
  logic [DW-1:0]       dt_q [WAYS];
  logic [DW-1:0]       dt_d [WAYS];
  logic [IW-1:0]       rk_q [WAYS];
  logic [IW-1:0]       rk_d [WAYS];
  logic [WAYS-1:0]     vl_q, vl_d;
  logic [COST_W-1:0]   cost_arr [NCOST];

  logic                inv_found, lru_found, cost_mono;
  logic [IW-1:0]       inv_way, lru_way, vic_c, tgt;
  logic [IW-1:0]       best_rk;
  logic [CREDIT_W-1:0] min_cr, floor_c, wr_cr;
  logic [CREDIT_W:0]   floor_w, sum_w;
  logic [DW-1:0]       hit_dt;
  logic                miss, hit_wr, hit_rd;

  assign miss   = acc_vld & ~acc_hit;
  assign hit_wr = acc_vld & acc_hit & acc_wr;
  assign hit_rd = acc_vld & acc_hit & ~acc_wr;
  assign hit_dt = dt_q[acc_way];

  always_comb begin
    cost_mono = 1'b1;
    for (int i = 0; i < NCOST; i++) begin
      cost_arr[i] = cost_tbl[i*COST_W +: COST_W];
      if (i > 0 && cost_arr[i] > cost_arr[i-1]) cost_mono = 1'b0;
    end
  end

  assign floor_w = {1'b0, ONE_C} + (CREDIT_W+1)'(cost_arr[0]);
  assign floor_c = floor_w[CREDIT_W] ? CMAX : floor_w[CREDIT_W-1:0];
  assign sum_w   = {1'b0, cr_q[acc_way]} + (CREDIT_W+1)'(cost_arr[hit_dt]);

  always_comb begin
    wr_cr = sum_w[CREDIT_W] ? CMAX : sum_w[CREDIT_W-1:0];
    if (wr_cr < floor_c) wr_cr = floor_c;
  end

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vl_q[w]) begin
        inv_found = 1'b1;
        inv_way   = IW'(w);
      end
    end
    min_cr = CMAX;
    for (int w = 0; w < WAYS; w++)
      if (cr_q[w] < min_cr) min_cr = cr_q[w];
    lru_found = 1'b0;
    lru_way   = '0;
    best_rk   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cr_q[w] == min_cr && (!lru_found || rk_q[w] > best_rk)) begin
        lru_found = 1'b1;
        best_rk   = rk_q[w];
        lru_way   = IW'(w);
      end
    end
  end

  assign vic_c = inv_found ? inv_way : lru_way;
  assign tgt   = acc_hit ? acc_way : vic_c;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cr_d[w] = cr_q[w];
      dt_d[w] = dt_q[w];
      rk_d[w] = rk_q[w];
    end
    vl_d = vl_q;
    if (acc_vld) begin
      if (acc_hit) begin
        if (acc_wr) begin
          cr_d[acc_way] = wr_cr;
          dt_d[acc_way] = (hit_dt == DMAX) ? hit_dt : hit_dt + DW'(1);
        end else if (hit_dt == '0) begin
          cr_d[acc_way] = ONE_C;
        end
      end else begin
        if (!inv_found)
          for (int w = 0; w < WAYS; w++) cr_d[w] = cr_q[w] - min_cr;
        cr_d[vic_c] = acc_wr ? floor_c : ONE_C;
        dt_d[vic_c] = acc_wr ? DW'(1) : '0;
        vl_d[vic_c] = 1'b1;
      end
      for (int w = 0; w < WAYS; w++) begin
        if (IW'(w) == tgt)          rk_d[w] = '0;
        else if (rk_q[w] < rk_q[tgt]) rk_d[w] = rk_q[w] + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q      <= '0;
      vic_vld   <= 1'b0;
      vic_way   <= '0;
      vic_dirty <= 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        cr_q[w] <= '0;
        dt_q[w] <= '0;
        rk_q[w] <= IW'(w);
      end
    end else begin
      vl_q      <= vl_d;
      vic_vld   <= miss;
      vic_way   <= vic_c;
      vic_dirty <= miss & ~inv_found & (dt_q[vic_c] != '0);
      for (int w = 0; w < WAYS; w++) begin
        cr_q[w] <= cr_d[w];
        dt_q[w] <= dt_d[w];
        rk_q[w] <= rk_d[w];
      end
    end
  end

  p_vic_after_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> vic_vld);
  p_no_vic_otherwise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |=> !vic_vld);
  p_empty_fill_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && inv_found) |=> (!vic_dirty && vic_way == $past(inv_way)));
  p_fill_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (cr_q[vic_way] == ($past(acc_wr) ? $past(floor_c) : ONE_C)));
  p_wr_hit_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wr |=> (cr_q[$past(acc_way)] >= $past(floor_c) && dt_q[$past(acc_way)] != '0));
  p_rd_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rd && hit_dt == '0) |=> (cr_q[$past(acc_way)] == ONE_C));
  p_rd_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rd && hit_dt != '0) |=> (cr_q[$past(acc_way)] == $past(cr_q[acc_way])));
  p_touch_newest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> (rk_q[$past(tgt)] == '0));
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wr |=> (cr_q[$past(acc_way)] >= $past(cr_q[acc_way])));
  p_hit_on_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit) |-> vl_q[acc_way]);
  p_cost_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> cost_mono);

endmodule

// File: tb/ttl_victim_sel_tb_top.sv
`timescale 1ns/1ps
module ttl_victim_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_vld = 1'b0, acc_hit = 1'b0, acc_wr = 1'b0;
  logic [1:0] acc_way = '0;
  logic [31:0] cost_tbl = {8'd1, 8'd2, 8'd4, 8'd8};
  logic       vic_vld, vic_dirty;
  logic [1:0] vic_way;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ttl_victim_sel #(.WAYS(4), .CREDIT_W(8), .FRAC(2), .NCOST(4), .COST_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_hit(acc_hit), .acc_way(acc_way),
    .acc_wr(acc_wr), .cost_tbl(cost_tbl), .vic_vld(vic_vld), .vic_way(vic_way),
    .vic_dirty(vic_dirty));

  // {hit, way[1:0], wr, exp_way[1:0], exp_dirty}; one unit = 4, c = 8,4,2,1
  localparam logic [6:0] VEC [23] = '{
    7'b0_00_0_01_0, // R4: drain 4, oldest zero is way1
    7'b0_00_0_10_0,
    7'b0_00_0_11_0,
    7'b0_00_0_01_0, // way0 still alive (R5 write fill credit)
    7'b0_00_0_10_0,
    7'b0_00_0_11_0,
    7'b0_00_1_00_1, // R9: way0 finally evicted, dirty
    7'b1_00_1_00_0, // R6: second write uses c2
    7'b1_01_0_00_0, // R7: clean read hit back to one unit
    7'b1_10_1_00_0, // R6: first write lifts to the floor
    7'b0_00_0_11_0,
    7'b0_00_0_01_0,
    7'b0_00_0_11_0,
    7'b1_10_0_00_0, // R7: dirty read hit keeps credit
    7'b0_00_0_01_0,
    7'b0_00_0_11_0,
    7'b0_00_0_10_1, // R8 ordering among zero ways, dirty victim
    7'b0_00_0_01_0,
    7'b0_00_0_11_0,
    7'b0_00_0_00_1, // R6: way0 lasted exactly as c2 predicts
    7'b1_10_0_00_0, // R8: refresh way2
    7'b0_00_0_01_0,
    7'b0_00_0_11_0
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic hit, input logic [1:0] way, input logic wr);
    @(negedge clk);
    acc_vld = 1'b1; acc_hit = hit; acc_way = way; acc_wr = wr;
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill_all(input logic first_wr);
    for (int w = 0; w < 4; w++) begin
      access(1'b0, 2'd0, (w == 0) ? first_wr : 1'b0);
      chk("R1 fill vld", int'(vic_vld), 1);
      chk("R3 fill order", int'(vic_way), w);
      chk("R1 fill clean", int'(vic_dirty), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0_hits;
    do_reset();
    chk("R1 reset vld", int'(vic_vld), 0);
    fill_all(1'b1);
    @(negedge clk);
    chk("R2 pulse ends", int'(vic_vld), 0);

    for (int i = 0; i < 23; i++) begin
      access(VEC[i][6], VEC[i][5:4], VEC[i][3]);
      if (VEC[i][6]) begin
        chk("R2 no report on hit", int'(vic_vld), 0);
      end else begin
        chk("R2 report after miss", int'(vic_vld), 1);
        chk("R4 victim way", int'(vic_way), int'(VEC[i][2:1]));
        chk("R9 victim dirty", int'(vic_dirty), int'(VEC[i][0]));
      end
    end

    // R10 and R6 saturation: many writes to way0, credit must pin at 255
    do_reset();
    chk("R1 reset vld again", int'(vic_vld), 0);
    fill_all(1'b0);
    for (int i = 0; i < 300; i++) access(1'b1, 2'd0, 1'b1);
    w0_hits = 0;
    for (int i = 0; i < 120; i++) begin
      access(1'b0, 2'd0, 1'b0);
      if (vic_way == 2'd0) w0_hits++;
    end
    chk("R10 saturated line survives drain", w0_hits, 0);
    chk("R4 round robin over zero ways", int'(vic_way), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule